// File: doc/BRIEF.md
# Timecode Card Status Word Builder and Checker

This block handles the four 32-bit status words that a timecode and clock-lock option card returns. It has two independent halves that share one clock. The encoder half takes a BCD timecode (hours, minutes, seconds, frames), a frame-rate code, drop-frame and video-standard flags, the input-valid and lock flags, and a 14-bit PLL phase. One cycle after a load strobe it presents the four words. Every byte carries a set marker bit in its top position, and all reserved bits are zero.

The checker half accepts four received words on its own load strobe. One cycle later it reports whether the marker pattern proves that a card is fitted, and it gives back the timecode fields, the flags and the rebuilt phase. It also raises a flag when a timecode digit is out of range. Both halves hold their outputs between strobes, so a host can sample them at leisure. Turning the phase into a frequency is left to the consumer.

Top module: `tcs_unit`

## Requirements
- R1: One cycle after `enc_load_i`, `enc_valid_o` pulses for one cycle. In words 0, 1 and 2, bits 31, 23, 15 and 7 are all 1.
- R2: Word 3 from the encoder is always 0x80008000: bits 31 and 15 set, every other bit clear.
- R3: Encoder word 0 holds the 7-bit BCD hours in bits 30:24, minutes in 22:16, seconds in 14:8 and frames in 6:0. In each field the tens digit is in the upper 3 bits and the units digit in the lower 4.
- R4: Encoder word 1 holds the rate code in bits 11:10 (00 = 24, 01 = 25, 10 = 29.97, 11 = 30 frames per second), drop-frame in bit 9, PAL in bit 6, NTSC in bit 5, word-clock-valid in bit 4, timecode-valid in bit 3 and lock in bit 0. Reserved bits 30:24, 22:16, 14:12, 8 and 2:1 are 0.
- R5: Encoder word 2 holds phase bits 13:7 in bits 14:8 and phase bits 6:0 in bits 6:0. Bits 30:24 and 22:16 are 0.
- R6: One cycle after `dec_load_i`, `dec_valid_o` pulses. `dec_present_o` is 1 only if all of these hold: bits 31, 23, 15 and 7 are set in received words 0 to 2; bits 31 and 15 are set in word 3; and bits 14:0 of word 3 are clear.
- R7: The checker returns the timecode fields and flags from the bit positions of R3 and R4. It returns the phase as the word-2 low field plus the word-2 high field shifted left by 7.
- R8: `dec_tc_bad_o` is 1 when any units digit exceeds 9, or when the hours tens digit exceeds 2, or when a minutes or seconds tens digit exceeds 5. The frames tens digit is not range-checked.
- R9: Reserved bits in the received words (word 1: 30:24, 22:16, 14:12, 8, 2:1; word 2: 30:24, 22:16; word 3: 30:16) have no effect on any checker output.
- R10: Reset clears every output to 0. Outputs keep their value while no load strobe is present, whatever the data inputs do.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| enc_load_i | input | 1 | Capture encoder inputs |
| enc_hours_i | input | 7 | BCD hours |
| enc_minutes_i | input | 7 | BCD minutes |
| enc_seconds_i | input | 7 | BCD seconds |
| enc_frames_i | input | 7 | BCD frames |
| enc_rate_i | input | 2 | Frame-rate code |
| enc_drop_i | input | 1 | Drop-frame active |
| enc_pal_i | input | 1 | PAL video present |
| enc_ntsc_i | input | 1 | NTSC video present |
| enc_wclk_ok_i | input | 1 | Word-clock input valid |
| enc_ltc_ok_i | input | 1 | Timecode input valid |
| enc_lock_i | input | 1 | Card locked |
| enc_phase_i | input | 14 | PLL phase |
| enc_valid_o | output | 1 | New words available |
| enc_q0_o | output | 32 | Status word 0 |
| enc_q1_o | output | 32 | Status word 1 |
| enc_q2_o | output | 32 | Status word 2 |
| enc_q3_o | output | 32 | Status word 3 |
| dec_load_i | input | 1 | Capture received words |
| dec_q0_i | input | 32 | Received word 0 |
| dec_q1_i | input | 32 | Received word 1 |
| dec_q2_i | input | 32 | Received word 2 |
| dec_q3_i | input | 32 | Received word 3 |
| dec_valid_o | output | 1 | Decoded result available |
| dec_present_o | output | 1 | Marker pattern matched |
| dec_tc_bad_o | output | 1 | Timecode digit out of range |
| dec_hours_o | output | 7 | Decoded hours |
| dec_minutes_o | output | 7 | Decoded minutes |
| dec_seconds_o | output | 7 | Decoded seconds |
| dec_frames_o | output | 7 | Decoded frames |
| dec_rate_o | output | 2 | Decoded rate code |
| dec_drop_o | output | 1 | Decoded drop-frame |
| dec_pal_o | output | 1 | Decoded PAL flag |
| dec_ntsc_o | output | 1 | Decoded NTSC flag |
| dec_wclk_ok_o | output | 1 | Decoded word-clock-valid |
| dec_ltc_ok_o | output | 1 | Decoded timecode-valid |
| dec_lock_o | output | 1 | Decoded lock |
| dec_phase_o | output | 14 | Rebuilt phase |

## Verification
Encoding a new status set and checking a received block can happen in the same cycle, because the two halves have separate strobes and separate output registers. The bench raises both strobes on the same edge, with unrelated data on each side, and also runs back-to-back decodes. Each half's result is compared against its own queue of expected values, so any leakage between the halves, or a result that lands one cycle late, shows up as a mismatch. After the last strobe the bench changes the data inputs without a strobe and confirms that the outputs stay frozen.

// File: rtl/tcs_pkg.sv
package tcs_pkg;
  localparam int QW      = 32;
  localparam int BW      = 8;
  localparam int PW      = BW - 1;
  localparam int NB      = QW / BW;
  localparam int NQ_DATA = 3;
  localparam int NQ      = NQ_DATA + 1;
  localparam int HALF_W  = PW;
  localparam int PHASE_W = 2 * HALF_W;
  localparam logic [QW-1:0] TAIL_WORD = 32'h8000_8000;

  typedef logic [PW-1:0] pay_t;

  typedef struct packed {
    pay_t hh;
    pay_t mm;
    pay_t ss;
    pay_t ff;
  } tc_t;

  typedef struct packed {
    logic [1:0] rate;
    logic       drop;
    logic       pal;
    logic       ntsc;
    logic       wclk_ok;
    logic       ltc_ok;
    logic       lock;
  } flags_t;

  // Attach the marker bit above a 7-bit payload.
  function automatic logic [BW-1:0] mark_byte(pay_t p);
    return {1'b1, p};
  endfunction

  // A BCD field is out of range if its units digit exceeds 9 or its tens digit exceeds tens_max.
  function automatic logic bcd_bad(pay_t v, logic [2:0] tens_max);
    return (v[3:0] > 4'd9) || (v[6:4] > tens_max);
  endfunction

  // Rebuild the phase from its two 7-bit halves.
  function automatic logic [PHASE_W-1:0] join_phase(pay_t hi, pay_t lo);
    return PHASE_W'(lo) + (PHASE_W'(hi) << HALF_W);
  endfunction

  // The last word must carry bits 31 and 15 set and bits 14:0 clear.
  function automatic logic tail_ok(logic [QW-1:0] w);
    return w[QW-1] && w[QW/2-1] && (w[QW/2-2:0] == '0);
  endfunction
endpackage

// File: rtl/tcs_encoder.sv
module tcs_encoder
  import tcs_pkg::*;
(
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   load_i,
  input  tc_t                    tc_i,
  input  flags_t                 fl_i,
  input  logic [PHASE_W-1:0]     phase_i,
  output logic                   vld_o,
  output logic [NQ-1:0][QW-1:0]  q_o
);
  logic [NQ_DATA-1:0][NB-1:0][PW-1:0] pay;
  logic [NQ-1:0][QW-1:0]              q_nxt;

  // Payload of every byte, reserved positions zero.
  always_comb begin
    pay[0]    = tc_i;
    pay[1][3] = '0;
    pay[1][2] = '0;
    pay[1][1] = {3'b000, fl_i.rate, fl_i.drop, 1'b0};
    pay[1][0] = {fl_i.pal, fl_i.ntsc, fl_i.wclk_ok, fl_i.ltc_ok, 2'b00, fl_i.lock};
    pay[2][3] = '0;
    pay[2][2] = '0;
    pay[2][1] = phase_i[PHASE_W-1:HALF_W];
    pay[2][0] = phase_i[HALF_W-1:0];
  end

  always_comb begin
    for (int qi = 0; qi < NQ_DATA; qi++) begin
      for (int bi = 0; bi < NB; bi++) begin
        q_nxt[qi][bi*BW +: BW] = mark_byte(pay[qi][bi]);
      end
    end
    q_nxt[NQ-1] = TAIL_WORD;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      vld_o <= 1'b0;
      q_o   <= '0;
    end else begin
      vld_o <= load_i;
      if (load_i) q_o <= q_nxt;
    end
  end

  // R1: result strobe follows the load by one cycle
  p_enc_latency_r1: assert property (@(posedge clk) disable iff (!rst_n)
    load_i |=> vld_o);
  // R1: marker bits present on every delivered data word
  p_enc_markers_r1: assert property (@(posedge clk) disable iff (!rst_n)
    vld_o |-> (((q_o[0] & 32'h8080_8080) == 32'h8080_8080) &&
               ((q_o[1] & 32'h8080_8080) == 32'h8080_8080) &&
               ((q_o[2] & 32'h8080_8080) == 32'h8080_8080)));
  // R4: reserved bits of word 1 stay clear
  p_enc_rsv_zero_r4: assert property (@(posedge clk) disable iff (!rst_n)
    vld_o |-> ((q_o[1] & 32'h7F7F_7106) == '0));
  // R10: words frozen without a load
  p_enc_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
    !load_i |=> $stable(q_o));
endmodule

// File: rtl/tcs_lane_split.sv
module tcs_lane_split
  import tcs_pkg::*;
(
  input  logic [NQ-1:0][QW-1:0]              q_i,
  output logic                               present_o,
  output logic [NQ_DATA-1:0][NB-1:0][PW-1:0] pay_o
);
  logic [NQ_DATA*NB-1:0] mk_vec;
  logic                  rsv_unused;

  for (genvar qi = 0; qi < NQ_DATA; qi++) begin : g_word
    for (genvar bi = 0; bi < NB; bi++) begin : g_byte
      assign mk_vec[qi*NB + bi] = q_i[qi][bi*BW + PW];
      assign pay_o[qi][bi]      = q_i[qi][bi*BW +: PW];
    end
  end

  assign present_o  = (&mk_vec) && tail_ok(q_i[NQ-1]);
  assign rsv_unused = ^q_i[NQ-1][QW-2:QW/2];
endmodule

// File: rtl/tcs_field_dec.sv
module tcs_field_dec
  import tcs_pkg::*;
(
  input  logic [NQ_DATA-1:0][NB-1:0][PW-1:0] pay_i,
  output tc_t                                tc_o,
  output flags_t                             fl_o,
  output logic [PHASE_W-1:0]                 phase_o,
  output logic                               bad_o
);
  logic rsv_unused;

  assign tc_o = pay_i[0];

  assign fl_o.rate    = pay_i[1][1][3:2];
  assign fl_o.drop    = pay_i[1][1][1];
  assign fl_o.pal     = pay_i[1][0][6];
  assign fl_o.ntsc    = pay_i[1][0][5];
  assign fl_o.wclk_ok = pay_i[1][0][4];
  assign fl_o.ltc_ok  = pay_i[1][0][3];
  assign fl_o.lock    = pay_i[1][0][0];

  assign phase_o = join_phase(pay_i[2][1], pay_i[2][0]);

  assign bad_o = bcd_bad(tc_o.hh, 3'd2) || bcd_bad(tc_o.mm, 3'd5) ||
                 bcd_bad(tc_o.ss, 3'd5) || bcd_bad(tc_o.ff, 3'd7);

  assign rsv_unused = ^{pay_i[1][3], pay_i[1][2], pay_i[1][1][6:4], pay_i[1][1][0],
                        pay_i[1][0][2:1], pay_i[2][3], pay_i[2][2]};
endmodule

// File: rtl/tcs_unit.sv
module tcs_unit
  import tcs_pkg::*;
(
  input  logic                clk,
  input  logic                rst_n,
  input  logic                enc_load_i,
  input  logic [6:0]          enc_hours_i,
  input  logic [6:0]          enc_minutes_i,
  input  logic [6:0]          enc_seconds_i,
  input  logic [6:0]          enc_frames_i,
  input  logic [1:0]          enc_rate_i,
  input  logic                enc_drop_i,
  input  logic                enc_pal_i,
  input  logic                enc_ntsc_i,
  input  logic                enc_wclk_ok_i,
  input  logic                enc_ltc_ok_i,
  input  logic                enc_lock_i,
  input  logic [13:0]         enc_phase_i,
  output logic                enc_valid_o,
  output logic [31:0]         enc_q0_o,
  output logic [31:0]         enc_q1_o,
  output logic [31:0]         enc_q2_o,
  output logic [31:0]         enc_q3_o,
  input  logic                dec_load_i,
  input  logic [31:0]         dec_q0_i,
  input  logic [31:0]         dec_q1_i,
  input  logic [31:0]         dec_q2_i,
  input  logic [31:0]         dec_q3_i,
  output logic                dec_valid_o,
  output logic                dec_present_o,
  output logic                dec_tc_bad_o,
  output logic [6:0]          dec_hours_o,
  output logic [6:0]          dec_minutes_o,
  output logic [6:0]          dec_seconds_o,
  output logic [6:0]          dec_frames_o,
  output logic [1:0]          dec_rate_o,
  output logic                dec_drop_o,
  output logic                dec_pal_o,
  output logic                dec_ntsc_o,
  output logic                dec_wclk_ok_o,
  output logic                dec_ltc_ok_o,
  output logic                dec_lock_o,
  output logic [13:0]         dec_phase_o
);
  // ---------------- encoder half ----------------
  tc_t                   enc_tc;
  flags_t                enc_fl;
  logic [NQ-1:0][QW-1:0] enc_words;

  assign enc_tc = {enc_hours_i, enc_minutes_i, enc_seconds_i, enc_frames_i};
  assign enc_fl = {enc_rate_i, enc_drop_i, enc_pal_i, enc_ntsc_i,
                   enc_wclk_ok_i, enc_ltc_ok_i, enc_lock_i};

  tcs_encoder u_enc (
    .clk     (clk),
    .rst_n   (rst_n),
    .load_i  (enc_load_i),
    .tc_i    (enc_tc),
    .fl_i    (enc_fl),
    .phase_i (enc_phase_i),
    .vld_o   (enc_valid_o),
    .q_o     (enc_words)
  );

  assign enc_q0_o = enc_words[0];
  assign enc_q1_o = enc_words[1];
  assign enc_q2_o = enc_words[2];
  assign enc_q3_o = enc_words[3];

  // ---------------- checker half ----------------
  logic [NQ-1:0][QW-1:0]              rx_words;
  logic [NQ_DATA-1:0][NB-1:0][PW-1:0] rx_pay;
  logic                               rx_present;
  tc_t                                rx_tc;
  flags_t                             rx_fl;
  logic [PHASE_W-1:0]                 rx_phase;
  logic                               rx_bad;

  assign rx_words = {dec_q3_i, dec_q2_i, dec_q1_i, dec_q0_i};

  tcs_lane_split u_split (
    .q_i       (rx_words),
    .present_o (rx_present),
    .pay_o     (rx_pay)
  );

  tcs_field_dec u_fields (
    .pay_i   (rx_pay),
    .tc_o    (rx_tc),
    .fl_o    (rx_fl),
    .phase_o (rx_phase),
    .bad_o   (rx_bad)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      dec_valid_o   <= 1'b0;
      dec_present_o <= 1'b0;
      dec_tc_bad_o  <= 1'b0;
      dec_hours_o   <= '0;
      dec_minutes_o <= '0;
      dec_seconds_o <= '0;
      dec_frames_o  <= '0;
      dec_rate_o    <= '0;
      dec_drop_o    <= 1'b0;
      dec_pal_o     <= 1'b0;
      dec_ntsc_o    <= 1'b0;
      dec_wclk_ok_o <= 1'b0;
      dec_ltc_ok_o  <= 1'b0;
      dec_lock_o    <= 1'b0;
      dec_phase_o   <= '0;
    end else begin
      dec_valid_o <= dec_load_i;
      if (dec_load_i) begin
        dec_present_o <= rx_present;
        dec_tc_bad_o  <= rx_bad;
        dec_hours_o   <= rx_tc.hh;
        dec_minutes_o <= rx_tc.mm;
        dec_seconds_o <= rx_tc.ss;
        dec_frames_o  <= rx_tc.ff;
        dec_rate_o    <= rx_fl.rate;
        dec_drop_o    <= rx_fl.drop;
        dec_pal_o     <= rx_fl.pal;
        dec_ntsc_o    <= rx_fl.ntsc;
        dec_wclk_ok_o <= rx_fl.wclk_ok;
        dec_ltc_ok_o  <= rx_fl.ltc_ok;
        dec_lock_o    <= rx_fl.lock;
        dec_phase_o   <= rx_phase;
      end
    end
  end

  // R6: checker strobe follows its load by one cycle
  p_dec_latency_r6: assert property (@(posedge clk) disable iff (!rst_n)
    dec_load_i |=> dec_valid_o);
  // R6: a missing top marker in word 3 can never read as present
  p_dec_absent_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (dec_load_i && !dec_q3_i[31]) |=> !dec_present_o);
  // R7: phase equals the two halves side by side
  p_dec_phase_r7: assert property (@(posedge clk) disable iff (!rst_n)
    dec_load_i |=> (dec_phase_o == {$past(dec_q2_i[14:8]), $past(dec_q2_i[6:0])}));
  // R8: frames units above nine is flagged
  p_dec_bad_units_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (dec_load_i && (dec_q0_i[3:0] > 4'd9)) |=> dec_tc_bad_o);
  // R10: checker results frozen without a load
  p_dec_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
    !dec_load_i |=> ($stable(dec_phase_o) && $stable(dec_present_o) && $stable(dec_hours_o)));
endmodule

// File: tb/tb_tcs_unit.sv
`timescale 1ns/1ps
module tb_tcs_unit;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        enc_load_i = 1'b0;
  logic [6:0]  enc_hours_i = '0, enc_minutes_i = '0, enc_seconds_i = '0, enc_frames_i = '0;
  logic [1:0]  enc_rate_i = '0;
  logic        enc_drop_i = 0, enc_pal_i = 0, enc_ntsc_i = 0;
  logic        enc_wclk_ok_i = 0, enc_ltc_ok_i = 0, enc_lock_i = 0;
  logic [13:0] enc_phase_i = '0;
  logic        enc_valid_o;
  logic [31:0] enc_q0_o, enc_q1_o, enc_q2_o, enc_q3_o;
  logic        dec_load_i = 1'b0;
  logic [31:0] dec_q0_i = '0, dec_q1_i = '0, dec_q2_i = '0, dec_q3_i = '0;
  logic        dec_valid_o, dec_present_o, dec_tc_bad_o;
  logic [6:0]  dec_hours_o, dec_minutes_o, dec_seconds_o, dec_frames_o;
  logic [1:0]  dec_rate_o;
  logic        dec_drop_o, dec_pal_o, dec_ntsc_o, dec_wclk_ok_o, dec_ltc_ok_o, dec_lock_o;
  logic [13:0] dec_phase_o;

  int n_cmp = 0;
  int n_bad = 0;
  bit done  = 0;

  logic [127:0] enc_exp[$];
  string        enc_tag[$];
  logic [51:0]  dec_exp[$];
  string        dec_tag[$];

  always #10 clk = ~clk;

  tcs_unit dut (.*);

  task automatic chk(input string tag, input logic [127:0] act, input logic [127:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // Expected words, written from the field positions of R1..R5
  function automatic logic [127:0] build_words(input logic [6:0] h, m, s, f, input logic [1:0] r,
      input logic dr, pa, nt, wc, lt, lk, input logic [13:0] ph);
    logic [31:0] w0, w1, w2, w3;
    w0 = 32'h8080_8080 | (32'(h) << 24) | (32'(m) << 16) | (32'(s) << 8) | 32'(f);
    w1 = 32'h8080_8080 | (32'(r) << 10) | (32'(dr) << 9) | (32'(pa) << 6) | (32'(nt) << 5) |
         (32'(wc) << 4) | (32'(lt) << 3) | 32'(lk);
    w2 = 32'h8080_8080 | (32'(ph / 128) << 8) | 32'(ph % 128);
    w3 = 32'h8000_8000;
    return {w0, w1, w2, w3};
  endfunction

  function automatic logic digit_bad(input logic [6:0] v, input int lim);
    int u, t;
    u = int'(v) % 16;
    t = int'(v) / 16;
    return (u > 9) || (t > lim);
  endfunction

  function automatic logic [51:0] exp_decode(input logic [31:0] a, b, c, d);
    logic pres, bad;
    logic [13:0] ph;
    pres = ((a & 32'h8080_8080) == 32'h8080_8080) && ((b & 32'h8080_8080) == 32'h8080_8080) &&
           ((c & 32'h8080_8080) == 32'h8080_8080) && d[31] && (d[15:0] == 16'h8000);
    bad  = digit_bad(a[30:24], 2) || digit_bad(a[22:16], 5) ||
           digit_bad(a[14:8], 5) || digit_bad(a[6:0], 99);
    ph   = 14'(c[14:8]) * 14'd128 + 14'(c[6:0]);
    return {pres, bad, a[30:24], a[22:16], a[14:8], a[6:0], b[11:10], b[9], b[6], b[5],
            b[4], b[3], b[0], ph};
  endfunction

  function automatic logic [51:0] dec_actual();
    return {dec_present_o, dec_tc_bad_o, dec_hours_o, dec_minutes_o, dec_seconds_o,
            dec_frames_o, dec_rate_o, dec_drop_o, dec_pal_o, dec_ntsc_o, dec_wclk_ok_o,
            dec_ltc_ok_o, dec_lock_o, dec_phase_o};
  endfunction

  task automatic enc_go(input logic [6:0] h, m, s, f, input logic [1:0] r,
      input logic dr, pa, nt, wc, lt, lk, input logic [13:0] ph, input string tag);
    enc_hours_i = h; enc_minutes_i = m; enc_seconds_i = s; enc_frames_i = f;
    enc_rate_i = r; enc_drop_i = dr; enc_pal_i = pa; enc_ntsc_i = nt;
    enc_wclk_ok_i = wc; enc_ltc_ok_i = lt; enc_lock_i = lk; enc_phase_i = ph;
    enc_load_i = 1'b1;
    enc_exp.push_back(build_words(h, m, s, f, r, dr, pa, nt, wc, lt, lk, ph));
    enc_tag.push_back(tag);
  endtask

  task automatic dec_go(input logic [127:0] w, input logic [51:0] exp, input string tag);
    {dec_q0_i, dec_q1_i, dec_q2_i, dec_q3_i} = w;
    dec_load_i = 1'b1;
    dec_exp.push_back(exp);
    dec_tag.push_back(tag);
  endtask

  function automatic logic [51:0] exp_of(input logic [127:0] w);
    return exp_decode(w[127:96], w[95:64], w[63:32], w[31:0]);
  endfunction

  task automatic tick();
    @(negedge clk);
    enc_load_i = 1'b0;
    dec_load_i = 1'b0;
  endtask

  // Scoreboard monitor
  always @(negedge clk) begin
    if (rst_n) begin
      if (enc_valid_o) begin
        if (enc_exp.size() == 0) chk("R1 unexpected encoder strobe", 128'(1), 128'(0));
        else chk(enc_tag.pop_front(), {enc_q0_o, enc_q1_o, enc_q2_o, enc_q3_o}, enc_exp.pop_front());
      end
      if (dec_valid_o) begin
        if (dec_exp.size() == 0) chk("R6 unexpected checker strobe", 128'(1), 128'(0));
        else chk(dec_tag.pop_front(), 128'(dec_actual()), 128'(dec_exp.pop_front()));
      end
    end
  end

  initial begin
    repeat (5000) @(posedge clk);
    if (!done) begin
      n_cmp++;
      n_bad++;
      $display("FAIL watchdog expired actual=running expected=finished");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

  initial begin
    logic [127:0] good, w;
    logic [51:0]  snap;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R10: reset state
    chk("R10 reset encoder", {95'(0), enc_valid_o, enc_q0_o, enc_q1_o, enc_q2_o, enc_q3_o} , 128'(0));
    chk("R10 reset checker", 128'({dec_valid_o, dec_actual()}), 128'(0));

    // Encoder patterns
    enc_go(7'h23, 7'h59, 7'h59, 7'h29, 2'b11, 1, 0, 1, 1, 1, 1, 14'h3FFF, "R1 R3 R4 R5 full scale");
    tick();
    enc_go(7'h00, 7'h00, 7'h00, 7'h00, 2'b00, 0, 0, 0, 0, 0, 0, 14'h0000, "R1 R2 all zero");
    tick();
    enc_go(7'h12, 7'h34, 7'h56, 7'h07, 2'b01, 0, 1, 0, 0, 1, 0, 14'h0080, "R5 phase bit7 boundary");
    tick();
    enc_go(7'h01, 7'h02, 7'h03, 7'h04, 2'b10, 1, 0, 0, 1, 0, 1, 14'h007F, "R4 R5 low half full");
    tick();
    tick();

    // Checker patterns
    good = build_words(7'h23, 7'h59, 7'h59, 7'h29, 2'b10, 1, 1, 0, 1, 0, 1, 14'h2A55);
    dec_go(good, exp_of(good), "R6 R7 valid block present");
    tick();
    w = good; w[0] = 1'b1;
    dec_go(w, exp_of(w), "R6 tail low bit set absent");
    tick();
    w = good; w[64+23] = 1'b0;
    dec_go(w, exp_of(w), "R6 word1 marker clear absent");
    tick();
    w = good; w[15] = 1'b0;
    dec_go(w, exp_of(w), "R6 tail bit15 clear absent");
    tick();
    w = good; w[96+31] = 1'b0;
    dec_go(w, exp_of(w), "R6 word0 top marker clear absent");
    tick();
    w = build_words(7'h10, 7'h20, 7'h0A, 7'h05, 0, 0, 0, 0, 0, 0, 0, 14'h1234);
    dec_go(w, exp_of(w), "R8 seconds units ten bad");
    tick();
    w = build_words(7'h30, 7'h00, 7'h00, 7'h00, 0, 0, 0, 0, 0, 0, 0, 14'h0001);
    dec_go(w, exp_of(w), "R8 hours tens three bad");
    tick();
    w = build_words(7'h29, 7'h60, 7'h00, 7'h00, 0, 0, 0, 0, 0, 0, 0, 14'h0100);
    dec_go(w, exp_of(w), "R8 minutes tens six bad");
    tick();
    w = build_words(7'h29, 7'h59, 7'h59, 7'h70, 1, 0, 0, 1, 0, 0, 0, 14'h3F80);
    dec_go(w, exp_of(w), "R7 R8 edge values frames tens unchecked");
    tick();
    w = build_words(7'h00, 7'h00, 7'h00, 7'h7A, 0, 0, 0, 0, 0, 0, 0, 14'h0000);
    dec_go(w, exp_of(w), "R8 frames units bad");
    tick();
    // R9: reserved bits set, expectation from the clean words
    w = good;
    w[95:64] = w[95:64] | 32'h7F7F_7106;
    w[63:32] = w[63:32] | 32'h7F7F_0000;
    w[31:0]  = w[31:0]  | 32'h7FFF_0000;
    dec_go(w, exp_of(good), "R9 reserved bits ignored");
    tick();

    // Same cycle: both halves loaded together, then back-to-back decodes
    enc_go(7'h05, 7'h44, 7'h33, 7'h22, 2'b01, 0, 1, 1, 0, 1, 1, 14'h1555, "R1 R3 concurrent encode");
    w = build_words(7'h11, 7'h11, 7'h11, 7'h11, 2'b11, 0, 0, 0, 0, 0, 0, 14'h0AAA);
    dec_go(w, exp_of(w), "R7 concurrent decode");
    tick();
    dec_go(good, exp_of(good), "R7 back-to-back decode");
    tick();
    tick();
    tick();

    // R10: outputs frozen while inputs change without strobe
    snap = dec_actual();
    {dec_q0_i, dec_q1_i, dec_q2_i, dec_q3_i} = '0;
    enc_phase_i = 14'h0F0F;
    enc_hours_i = 7'h77;
    repeat (3) @(negedge clk);
    chk("R10 checker hold", 128'(dec_actual()), 128'(snap));
    chk("R10 encoder hold", {enc_q0_o, enc_q1_o, enc_q2_o, enc_q3_o},
        build_words(7'h05, 7'h44, 7'h33, 7'h22, 2'b01, 0, 1, 1, 0, 1, 1, 14'h1555));
    chk("R1 R6 queues drained", 128'(enc_exp.size() + dec_exp.size()), 128'(0));

    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule